// File: doc/BRIEF.md
# Pin interrupt controller

This block watches 32 external input lines and raises a single interrupt request towards a processor when one of them shows the event it has been set up to look for. Every line can trigger on a rising edge, a falling edge, both edges, a high level or a low level. The lines are asynchronous to the block clock. Each one passes through a two-flop synchroniser, and a third flop keeps the value from one clock earlier so that edges can be found.

Software drives the block through a simple 32-bit register bus with byte addresses and word-aligned accesses. A bank of four trigger-mode words holds a 4-bit field per line. One word holds a per-line enable mask. One word holds the pending bits, which are cleared by writing 1. A pending bit is recorded whether or not its line is enabled. The interrupt output is the registered OR of the pending bits that are also enabled. Reads complete in the same cycle, combinationally from the current register state.

Top module: `lirq_top`

## Requirements
- R1: After reset, every trigger-mode word, the enable word and the pending word read as zero, and `irq_o` is low.
- R2: The trigger field of line n is 4 bits wide at bit (n mod 8)*4 of the word at byte offset 0x200 + 4*(n div 8), so lines 0-7, 8-15, 16-23 and 24-31 use 0x200, 0x204, 0x208 and 0x20C. A written word reads back unchanged, including reserved codes.
- R3: The enable word is at offset 0x210 and the pending word is at offset 0x214. In both, bit n belongs to line n. The enable word reads back as written.
- R4: Code 0 sets the pending bit on a 0-to-1 change of the line, and code 1 sets it on a 1-to-0 change. A line change made between clock edges is visible in the pending word after the third rising clock edge, and is not yet visible after the second.
- R5: Code 2 sets the pending bit in every cycle in which the synchronised line is high. Code 3 does the same while the line is low.
- R6: Code 4 sets the pending bit on every change of the synchronised line, in either direction.
- R7: Codes 5 to 15 are reserved. A line that uses one of them never sets its pending bit.
- R8: Writing 1 to a pending bit clears it. Writing 0 to it leaves it unchanged.
- R9: When a trigger event and a write-1 clear hit the same pending bit in the same cycle, the bit stays set. In level modes, this means the bit cannot be cleared while the level is still active.
- R10: Pending bits are recorded regardless of the enable word. `irq_o` equals the OR over all lines of (pending AND enable) as it was one clock earlier.
- R11: Reads from any other address, including misaligned ones, return zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| line_i | input | 32 | External lines, asynchronous to clk_i |
| bus_sel_i | input | 1 | Register access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of a read access |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
The hardest case to reach from the ports is a clear that lands in the same cycle as a new event on the same bit. The clear is captured on one clock edge, and the event depends on a line change made three edges earlier. The bench reaches this case directly by holding a level-mode line active while it writes the clear. During a long random phase, sparse line flips, random clear masks and reserved codes mixed into the mode fields then run into it repeatedly. A cycle-level bench model predicts the pending word and `irq_o` throughout that phase.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

  localparam int unsigned LIRQ_LINES  = 32;
  localparam int unsigned LIRQ_MODE_W = 4;
  localparam int unsigned LIRQ_DATA_W = 32;
  localparam int unsigned LIRQ_ADDR_W = 12;

  // Byte offsets of the register bank
  localparam int unsigned LIRQ_CFG_BASE = 32'h200;
  localparam int unsigned LIRQ_ENA_OFS  = 32'h210;
  localparam int unsigned LIRQ_PEND_OFS = 32'h214;

  typedef enum logic [LIRQ_MODE_W-1:0] {
    TRIG_RISE = 4'd0,
    TRIG_FALL = 4'd1,
    TRIG_HIGH = 4'd2,
    TRIG_LOW  = 4'd3,
    TRIG_ANY  = 4'd4
  } trig_mode_e;

endpackage

// File: rtl/lirq_rst_sync.sv
module lirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/lirq_sync.sv
module lirq_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] cur_q;
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/lirq_detect.sv
module lirq_detect
  import lirq_pkg::*;
#(
  parameter int unsigned LINES  = LIRQ_LINES,
  parameter int unsigned MODE_W = LIRQ_MODE_W
) (
  input  logic [LINES*MODE_W-1:0] cfg_i,
  input  logic [LINES-1:0]        cur_i,
  input  logic [LINES-1:0]        prev_i,
  output logic [LINES-1:0]        event_o
);

  for (genvar n = 0; n < LINES; n++) begin : g_line
    logic [MODE_W-1:0] mode;
    assign mode = cfg_i[n*MODE_W +: MODE_W];

    always_comb begin
      case (mode)
        TRIG_RISE: event_o[n] =  cur_i[n] & ~prev_i[n];
        TRIG_FALL: event_o[n] = ~cur_i[n] &  prev_i[n];
        TRIG_HIGH: event_o[n] =  cur_i[n];
        TRIG_LOW:  event_o[n] = ~cur_i[n];
        TRIG_ANY:  event_o[n] =  cur_i[n] ^  prev_i[n];
        default:   event_o[n] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/lirq_regs.sv
module lirq_regs
  import lirq_pkg::*;
#(
  parameter int unsigned LINES  = LIRQ_LINES,
  parameter int unsigned MODE_W = LIRQ_MODE_W,
  parameter int unsigned DATA_W = LIRQ_DATA_W,
  parameter int unsigned ADDR_W = LIRQ_ADDR_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bus_sel_i,
  input  logic                    bus_wr_i,
  input  logic [ADDR_W-1:0]       bus_addr_i,
  input  logic [DATA_W-1:0]       bus_wdata_i,
  output logic [DATA_W-1:0]       bus_rdata_o,
  input  logic [LINES-1:0]        event_i,
  output logic [LINES*MODE_W-1:0] cfg_o,
  output logic [LINES-1:0]        enable_o,
  output logic [LINES-1:0]        status_o,
  output logic [LINES-1:0]        clr_o,
  output logic                    irq_o
);

  localparam int unsigned FIELDS    = DATA_W / MODE_W;
  localparam int unsigned CFG_WORDS = LINES / FIELDS;
  localparam logic [ADDR_W-1:0] ENA_ADDR  = ADDR_W'(LIRQ_ENA_OFS);
  localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'(LIRQ_PEND_OFS);

  logic                  wr_strobe;
  logic [CFG_WORDS-1:0]  cfg_hit;
  logic [DATA_W-1:0]     cfg_q [CFG_WORDS];
  logic                  ena_hit;
  logic                  pend_hit;
  logic                  ena_we;
  logic [LINES-1:0]      enable_q;
  logic [LINES-1:0]      enable_d;
  logic [LINES-1:0]      status_q;
  logic [LINES-1:0]      status_d;
  logic [LINES-1:0]      clr_mask;
  logic                  irq_q;
  logic                  irq_d;

  assign wr_strobe = bus_sel_i & bus_wr_i;
  assign ena_hit   = bus_sel_i & (bus_addr_i == ENA_ADDR);
  assign pend_hit  = bus_sel_i & (bus_addr_i == PEND_ADDR);

  // Trigger-mode words, one register per group of lines
  for (genvar k = 0; k < CFG_WORDS; k++) begin : g_cfg
    localparam logic [ADDR_W-1:0] WORD_ADDR = ADDR_W'(LIRQ_CFG_BASE + 4 * k);
    logic              we;
    logic [DATA_W-1:0] nxt;

    assign cfg_hit[k] = bus_sel_i & (bus_addr_i == WORD_ADDR);
    assign we         = wr_strobe & cfg_hit[k];

    always_comb begin
      nxt = cfg_q[k];
      if (we) begin
        nxt = bus_wdata_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[k] <= '0;
      end else begin
        cfg_q[k] <= nxt;
      end
    end

    assign cfg_o[k*DATA_W +: DATA_W] = cfg_q[k];
  end

  // Enable mask
  assign ena_we = wr_strobe & ena_hit;

  always_comb begin
    enable_d = enable_q;
    if (ena_we) begin
      enable_d = bus_wdata_i[LINES-1:0];
    end
  end

  // Pending word: write-1 clear, new events take priority
  always_comb begin
    clr_mask = '0;
    if (wr_strobe && pend_hit) begin
      clr_mask = bus_wdata_i[LINES-1:0];
    end
    status_d = (status_q & ~clr_mask) | event_i;
    irq_d    = |(status_q & enable_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= '0;
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      enable_q <= enable_d;
      status_q <= status_d;
      irq_q    <= irq_d;
    end
  end

  // Read path
  always_comb begin
    bus_rdata_o = '0;
    for (int k = 0; k < CFG_WORDS; k++) begin
      if (cfg_hit[k]) begin
        bus_rdata_o = cfg_q[k];
      end
    end
    if (ena_hit) begin
      bus_rdata_o = DATA_W'(enable_q);
    end
    if (pend_hit) begin
      bus_rdata_o = DATA_W'(status_q);
    end
  end

  assign enable_o = enable_q;
  assign status_o = status_q;
  assign clr_o    = clr_mask;
  assign irq_o    = irq_q;

endmodule

// File: rtl/lirq_top.sv
module lirq_top
  import lirq_pkg::*;
#(
  parameter int unsigned LINES  = LIRQ_LINES,
  parameter int unsigned MODE_W = LIRQ_MODE_W,
  parameter int unsigned DATA_W = LIRQ_DATA_W,
  parameter int unsigned ADDR_W = LIRQ_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINES-1:0]  line_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);

  logic                    rst_int_n;
  logic [LINES-1:0]        line_cur;
  logic [LINES-1:0]        line_prev;
  logic [LINES-1:0]        trig_event;
  logic [LINES*MODE_W-1:0] cfg_flat;
  logic [LINES-1:0]        enable_vec;
  logic [LINES-1:0]        status_vec;
  logic [LINES-1:0]        clr_vec;

  lirq_rst_sync #(
    .STAGES (2)
  ) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  lirq_sync #(
    .WIDTH (LINES)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .async_i (line_i),
    .cur_o   (line_cur),
    .prev_o  (line_prev)
  );

  lirq_detect #(
    .LINES  (LINES),
    .MODE_W (MODE_W)
  ) u_detect (
    .cfg_i   (cfg_flat),
    .cur_i   (line_cur),
    .prev_i  (line_prev),
    .event_o (trig_event)
  );

  lirq_regs #(
    .LINES  (LINES),
    .MODE_W (MODE_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_int_n),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .event_i     (trig_event),
    .cfg_o       (cfg_flat),
    .enable_o    (enable_vec),
    .status_o    (status_vec),
    .clr_o       (clr_vec),
    .irq_o       (irq_o)
  );

endmodule

// File: rtl/lirq_checker.sv
module lirq_checker
  import lirq_pkg::*;
#(
  parameter int unsigned LINES  = LIRQ_LINES,
  parameter int unsigned MODE_W = LIRQ_MODE_W
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [LINES-1:0]        event_i,
  input logic [LINES-1:0]        status_i,
  input logic [LINES-1:0]        enable_i,
  input logic [LINES-1:0]        clr_i,
  input logic [LINES*MODE_W-1:0] cfg_i,
  input logic                    irq_i
);

  logic [LINES-1:0] reserved_line;

  always_comb begin
    for (int n = 0; n < LINES; n++) begin
      reserved_line[n] = (cfg_i[n*MODE_W +: MODE_W] > MODE_W'(TRIG_ANY));
    end
  end

  AST_RESERVED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i & reserved_line) == '0);  // R7

  AST_SET_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_i & ~$past(status_i) & ~$past(event_i)) == '0));  // R4

  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~status_i & $past(status_i) & ~$past(clr_i)) == '0));  // R8

  AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_i & $past(event_i)) == $past(event_i)));  // R9

  AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(status_i & enable_i)) |=> irq_i);  // R10

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(status_i & enable_i)) |=> !irq_i);  // R10

endmodule

bind lirq_top lirq_checker #(
  .LINES  (LINES),
  .MODE_W (MODE_W)
) u_lirq_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_int_n),
  .event_i  (trig_event),
  .status_i (status_vec),
  .enable_i (enable_vec),
  .clr_i    (clr_vec),
  .cfg_i    (cfg_flat),
  .irq_i    (irq_o)
);

// File: tb/test_lirq_top.sv
`timescale 1ns/1ps
module test_lirq_top;

  logic        clk;
  logic        rst_n;
  logic [31:0] lines;
  logic        sel;
  logic        wr;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_err = 0;
  int irq_chk = 0;
  int irq_err = 0;
  int wd_err = 0;
  bit done = 0;

  lirq_top i_lirq_top (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .line_i      (lines),
    .bus_sel_i   (sel),
    .bus_wr_i    (wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- reference model built from the requirements ----------------
  logic [1:0]  m_rs;
  logic        m_ok;
  logic [31:0] m_s1, m_s2, m_prev, m_en, m_st, m_ev;
  logic [31:0] m_cfg [4];
  logic        m_irq;

  function automatic logic trig_hit(logic [3:0] m, logic c, logic p);
    case (m)
      4'd0:    return c & ~p;
      4'd1:    return ~c & p;
      4'd2:    return c;
      4'd3:    return ~c;
      4'd4:    return c ^ p;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_rs <= 2'b00;
    else        m_rs <= {m_rs[0], 1'b1};
  end
  assign m_ok = m_rs[1];

  always_comb begin
    for (int n = 0; n < 32; n++) begin
      m_ev[n] = trig_hit(m_cfg[n/8][(n%8)*4 +: 4], m_s2[n], m_prev[n]);
    end
  end

  always @(posedge clk or negedge m_ok) begin
    if (!m_ok) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_en <= '0; m_st <= '0; m_irq <= 1'b0;
      for (int k = 0; k < 4; k++) m_cfg[k] <= '0;
    end else begin
      m_s1   <= lines;
      m_s2   <= m_s1;
      m_prev <= m_s2;
      m_irq  <= |(m_st & m_en);
      m_st   <= (m_st & ~((sel && wr && addr == 12'h214) ? wdata : 32'h0)) | m_ev;
      if (sel && wr) begin
        if (addr == 12'h210) m_en <= wdata;
        for (int k = 0; k < 4; k++) begin
          if (addr == 12'h200 + 12'(4 * k)) m_cfg[k] <= wdata;
        end
      end
    end
  end

  // R10: irq_o compared with the model in every cycle after reset
  always @(negedge clk) begin
    if (m_ok && !done) begin
      irq_chk++;
      if (irq_o !== m_irq) begin
        irq_err++;
        $display("FAIL R10 irq_o actual=%0b expected=%0b at %0t", irq_o, m_irq, $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_reg(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_now(logic [11:0] a, string req, logic [31:0] exp);
    sel = 1'b1; wr = 1'b0; addr = a;
    #0.5;
    chk(req, rdata, exp);
    sel = 1'b0;
  endtask

  task automatic rd_chk(logic [11:0] a, string req, logic [31:0] exp);
    @(negedge clk);
    rd_now(a, req, exp);
  endtask

  task automatic set_line(int n, logic v);
    @(negedge clk);
    lines[n] = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err + irq_err + wd_err, n_chk + irq_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      wd_err = 1;
      $display("FAIL watchdog actual=running expected=finished");
      done = 1;
      summary();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd7321));
    rst_n = 1'b0; lines = '0; sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 irq during reset", {31'b0, irq_o}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset values
    for (int k = 0; k < 4; k++) rd_chk(12'h200 + 12'(4 * k), "R1 cfg", 32'h0);
    rd_chk(12'h210, "R1 enable", 32'h0);
    rd_chk(12'h214, "R1 status", 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);

    // R3: enable readback
    wr_reg(12'h210, 32'hA5A5_0F0F);
    rd_chk(12'h210, "R3 enable readback", 32'hA5A5_0F0F);
    wr_reg(12'h210, 32'h0);

    // R2 + R5: line 13 high level, field at word 0x204 bits 23:20
    wr_reg(12'h204, 32'h0020_0000);
    rd_chk(12'h204, "R2 cfg readback", 32'h0020_0000);
    set_line(13, 1'b1);
    rd_chk(12'h214, "R5 high level sets", 32'h0000_2000);
    // R9: clear while level still active loses
    wr_reg(12'h214, 32'h0000_2000);
    rd_chk(12'h214, "R9 level persists over clear", 32'h0000_2000);
    set_line(13, 1'b0);
    // R8: write 0 no effect, write 1 clears
    wr_reg(12'h214, 32'h0);
    rd_chk(12'h214, "R8 write zero keeps", 32'h0000_2000);
    wr_reg(12'h214, 32'h0000_2000);
    rd_chk(12'h214, "R8 write one clears", 32'h0);

    // R4: rising on line 0 with latency check
    @(negedge clk);
    lines[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd_now(12'h214, "R4 not yet after two edges", 32'h0);
    @(negedge clk);
    rd_now(12'h214, "R4 set after third edge", 32'h1);
    wr_reg(12'h214, 32'h1);
    repeat (3) @(negedge clk);
    rd_chk(12'h214, "R4 held high no new edge", 32'h0);

    // R4: falling on line 1
    wr_reg(12'h200, 32'h0000_0010);
    set_line(1, 1'b1);
    rd_chk(12'h214, "R4 falling ignores rise", 32'h0);
    set_line(1, 1'b0);
    rd_chk(12'h214, "R4 falling sets", 32'h2);
    wr_reg(12'h214, 32'h2);

    // R6: both edges on line 2
    wr_reg(12'h200, 32'h0000_0410);
    set_line(2, 1'b1);
    rd_chk(12'h214, "R6 rise sets", 32'h4);
    wr_reg(12'h214, 32'h4);
    set_line(2, 1'b0);
    rd_chk(12'h214, "R6 fall sets", 32'h4);
    wr_reg(12'h214, 32'h4);
    rd_chk(12'h214, "R6 cleared", 32'h0);

    // R5: low level on line 3 (line is low)
    wr_reg(12'h200, 32'h0000_3410);
    rd_chk(12'h214, "R5 low level sets", 32'h8);
    set_line(3, 1'b1);
    wr_reg(12'h214, 32'h8);
    rd_chk(12'h214, "R5 cleared after level gone", 32'h0);

    // R7: reserved codes on line 4
    wr_reg(12'h200, 32'h000F_3410);
    set_line(4, 1'b1);
    set_line(4, 1'b0);
    rd_chk(12'h214, "R7 code 15 silent", 32'h0);
    wr_reg(12'h200, 32'h0005_3410);
    set_line(4, 1'b1);
    set_line(4, 1'b0);
    rd_chk(12'h214, "R7 code 5 silent", 32'h0);
    rd_chk(12'h200, "R2 reserved readback", 32'h0005_3410);

    // R2: last line in the last word
    wr_reg(12'h20C, 32'h4000_0000);
    set_line(31, 1'b1);
    rd_chk(12'h214, "R2 line 31 field", 32'h8000_0000);
    wr_reg(12'h214, 32'h8000_0000);
    set_line(31, 1'b0);

    // R10: pending while disabled, then enabled
    rd_chk(12'h214, "R10 pending while disabled", 32'h8000_0000);
    chk("R10 irq low while disabled", {31'b0, irq_o}, 32'h0);
    wr_reg(12'h210, 32'h8000_0000);
    chk("R10 irq one cycle after enable", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R10 irq raised", {31'b0, irq_o}, 32'h1);
    wr_reg(12'h214, 32'h8000_0000);
    chk("R10 irq still registered", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    chk("R10 irq dropped", {31'b0, irq_o}, 32'h0);

    // R11: unmapped accesses
    rd_chk(12'h218, "R11 unmapped read", 32'h0);
    rd_chk(12'h1FC, "R11 unmapped read below", 32'h0);
    rd_chk(12'h202, "R11 misaligned read", 32'h0);
    wr_reg(12'h218, 32'hFFFF_FFFF);
    wr_reg(12'h206, 32'hFFFF_FFFF);
    rd_chk(12'h200, "R11 cfg0 untouched", 32'h0005_3410);
    rd_chk(12'h204, "R11 cfg1 untouched", 32'h0020_0000);
    rd_chk(12'h210, "R11 enable untouched", 32'h8000_0000);

    // Random phase against the model (R4, R5, R6, R7, R8, R9, R10)
    for (int i = 0; i < 4000; i++) begin
      int r;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
      if ($urandom_range(3) == 0) lines = lines ^ ($urandom & $urandom & $urandom);
      r = $urandom_range(99);
      if (r < 10) begin
        sel = 1'b1; wr = 1'b1; addr = 12'h214; wdata = $urandom;
      end else if (r < 13) begin
        sel = 1'b1; wr = 1'b1; addr = 12'h210; wdata = $urandom;
      end else if (r < 15) begin
        logic [31:0] d;
        for (int j = 0; j < 8; j++) begin
          d[j*4 +: 4] = ($urandom_range(9) < 8) ? 4'($urandom_range(4)) : 4'($urandom_range(15));
        end
        sel = 1'b1; wr = 1'b1; addr = 12'h200 + 12'(4 * $urandom_range(3)); wdata = d;
      end else if (r < 40) begin
        rd_now(12'h214, "R6 random status vs model", m_st);
      end else if (r < 44) begin
        rd_now(12'h210, "R3 random enable vs model", m_en);
      end
    end
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
    for (int k = 0; k < 4; k++) rd_chk(12'h200 + 12'(4 * k), "R2 final cfg vs model", m_cfg[k]);
    rd_chk(12'h214, "R9 final status vs model", m_st);

    done = 1;
    summary();
    $finish;
  end

endmodule